// File: doc/BRIEF.md
# Interleaved Device-to-Host Address Translator

This block turns an offset within a memory device into the matching offset in host address space, for a region whose lines are spread across several targets. The caller presents the device offset, the target's slot in the interleave set, an encoded way count, an encoded interleave granularity, an encoded host-bridge way count and a mode bit. The block then returns the host offset that this slot owns.

Plain modulo interleaving inserts the slot number above the granule offset. Way counts of three, six and twelve are handled by scaling the upper address field by three. When XOR mode is selected, the modulo result passes through a chain of parity stages. Each stage rewrites one selector bit from the parity of a group of host address bits, and the host-bridge way count sets how many stages act.

Requests are accepted one per cycle. Each result appears one cycle later with a valid strobe. Malformed requests are flagged, and the address output is forced to all ones for them.

Top module: `ilv_addr_xlate`

## Requirements
- R1: Way codes 0, 1, 2, 3, 4, 8, 9 and 10 mean 1, 2, 4, 8, 16, 3, 6 and 12 ways. Any other way code sets outError, and hostOffset then reads all ones.
- R2: With granularity G = 256 << granCode, the low (granCode+8) bits of devOffset appear unchanged in hostOffset.
- R3: For power-of-two way codes, the device field at and above bit (granCode+8) is shifted left by the way code in place, and targetPos is placed at bit (granCode+8). For example, 4 ways at granCode 0 with offset 256 gives 1024 + 256·pos.
- R4: For way codes 8 to 10, the right-justified upper field is multiplied by 3 and shifted left by (code−8). targetPos is added, the sum is shifted left by (granCode+8), and the low bits are added. For example, 12 ways at granCode 0 with offset 512 gives 6144 + 256·pos.
- R5: In XOR mode the modulo result passes through a chain of stages, applied in this order, with bit masks 0x2020900, 0x4041200, 0x1010400 and 0x800. Each stage sets the lowest bit of its mask to the parity of the address ANDed with that mask. Host way codes 0/8 use 0 stages, 1/9 use 1 stage, 2/10 use 2, 3 uses 3 and 4 uses 4.
- R6: outValid is high exactly in the cycle after a cycle with inValid high. hostOffset holds its value when no request is taken.
- R7: A targetPos at or above the decoded way count sets outError.
- R8: granCode values 0 to 6 are accepted. Values 7 and above set outError.
- R9: During and after reset, before any request, outValid, outError and hostOffset are all zero.
- R10: hostWaysCode has no effect in modulo mode, even when it is not a legal code. In XOR mode an illegal hostWaysCode (outside the set listed in R1) sets outError.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| devOffset | input | 52 | Device physical address offset |
| targetPos | input | 4 | Slot of this target in the interleave set |
| waysCode | input | 4 | Encoded region way count |
| granCode | input | 4 | Encoded granularity (256 B << code) |
| hostWaysCode | input | 4 | Encoded host-bridge way count, selects XOR stage count |
| xorMode | input | 1 | 1 = XOR restore after modulo, 0 = modulo only |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outError | output | 1 | Request was malformed |
| hostOffset | output | 52 | Host physical address offset, all ones on error |

## Verification
Every result, whether address, error flag or valid strobe, is due exactly one clock edge after the edge that samples the request. Nothing in the path adds extra cycles. The driver applies each request on a falling edge and queues its expected result. The monitor looks 1 ns after every rising edge and pops one item whenever outValid is high. A strobe with an empty queue, or items left in the queue at the end, counts as a latency error. Back-to-back requests are used so that a result arriving a cycle late is caught by mismatched values.

// File: rtl/ilv_xlate_pkg.sv
package ilv_xlate_pkg;

  localparam int CODE_W = 4;

  // Strobes and decoded fields handed from control to datapath
  typedef struct packed {
    logic       load;
    logic       fault;
    logic       triple;
    logic       useXor;
    logic [2:0] waysShift;
    logic [2:0] xorStages;
  } xlateStrobeT;

  function automatic logic [4:0] waysCount(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 5'd1;
      4'd1:    return 5'd2;
      4'd2:    return 5'd4;
      4'd3:    return 5'd8;
      4'd4:    return 5'd16;
      4'd8:    return 5'd3;
      4'd9:    return 5'd6;
      4'd10:   return 5'd12;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [2:0] waysShiftOf(input logic [CODE_W-1:0] code);
    case (code)
      4'd1, 4'd9:  return 3'd1;
      4'd2, 4'd10: return 3'd2;
      4'd3:        return 3'd3;
      4'd4:        return 3'd4;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] xorStagesOf(input logic [CODE_W-1:0] code);
    case (code)
      4'd1, 4'd9:  return 3'd1;
      4'd2, 4'd10: return 3'd2;
      4'd3:        return 3'd3;
      4'd4:        return 3'd4;
      default:     return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ilv_xlate_ctrl.sv
module ilv_xlate_ctrl
  import ilv_xlate_pkg::*;
#(
  parameter int POS_W    = 4,
  parameter int GRAN_MAX = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [POS_W-1:0]  targetPos,
  input  logic [CODE_W-1:0] waysCode,
  input  logic [CODE_W-1:0] granCode,
  input  logic [CODE_W-1:0] hostWaysCode,
  input  logic              xorMode,
  output xlateStrobeT       strobe,
  output logic              outValid,
  output logic              outError
);

  logic [4:0] wayCnt;
  logic       waysOk;
  logic       hostOk;
  logic       granOk;
  logic       posOk;
  logic       fault;

  always_comb begin
    wayCnt = waysCount(waysCode);
    waysOk = (wayCnt != 5'd0);
    hostOk = (waysCount(hostWaysCode) != 5'd0);
    granOk = (int'(granCode) <= GRAN_MAX);
    posOk  = (int'(targetPos) < int'(wayCnt));
    fault  = !waysOk || !granOk || !posOk || (xorMode && !hostOk);
  end

  always_comb begin
    strobe.load      = inValid;
    strobe.fault     = fault;
    strobe.triple    = waysCode[3];
    strobe.useXor    = xorMode;
    strobe.waysShift = waysShiftOf(waysCode);
    strobe.xorStages = xorStagesOf(hostWaysCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outError <= 1'b0;
    end else begin
      outValid <= inValid;
      outError <= inValid && fault;
    end
  end

  // R6: strobe follows the request by one cycle
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_err_with_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    outError |-> outValid);
  // R1: illegal way codes are flagged
  p_bad_ways_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (waysCode inside {[4'd5:4'd7], [4'd11:4'd15]})) |=> outError);
  // R8: oversize granularity is flagged
  p_bad_gran_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (int'(granCode) > GRAN_MAX)) |=> outError);
  // R10: illegal host code in XOR mode is flagged
  p_bad_host_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && xorMode && (hostWaysCode inside {[4'd5:4'd7], [4'd11:4'd15]})) |=> outError);

endmodule

// File: rtl/ilv_xlate_xor.sv
module ilv_xlate_xor #(
  parameter int ADDR_W   = 52,
  parameter int NUM_MAPS = 4,
  parameter logic [NUM_MAPS-1:0][ADDR_W-1:0] MAPS = '0
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        stageCount,
  output logic [ADDR_W-1:0] addrOut
);

  function automatic int lowestSet(input logic [ADDR_W-1:0] m);
    int r;
    r = 0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] chain [NUM_MAPS+1];

  assign chain[0] = addrIn;

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_stage
    localparam logic [ADDR_W-1:0] MAP = MAPS[g];
    localparam int PIVOT = lowestSet(MAP);
    always_comb begin
      chain[g+1] = chain[g];
      if ((MAP != '0) && (int'(stageCount) > g)) begin
        chain[g+1][PIVOT] = ^(chain[g] & MAP);
      end
    end
  end

  assign addrOut = chain[NUM_MAPS];

endmodule

// File: rtl/ilv_xlate_dp.sv
module ilv_xlate_dp
  import ilv_xlate_pkg::*;
#(
  parameter int ADDR_W   = 52,
  parameter int POS_W    = 4,
  parameter int NUM_MAPS = 4,
  parameter logic [NUM_MAPS-1:0][ADDR_W-1:0] MAPS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobeT       strobe,
  input  logic [ADDR_W-1:0] devOffset,
  input  logic [POS_W-1:0]  targetPos,
  input  logic [CODE_W-1:0] granCode,
  output logic [ADDR_W-1:0] hostOffset
);

  localparam int CUT_W = 5;

  logic [CUT_W-1:0]  cut;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] lowBits;
  logic [ADDR_W-1:0] upperInPlace;
  logic [ADDR_W-1:0] upperJust;
  logic [ADDR_W-1:0] posWide;
  logic [ADDR_W-1:0] tripled;
  logic [ADDR_W-1:0] pow2Sum;
  logic [ADDR_W-1:0] triSum;
  logic [ADDR_W-1:0] modHpa;
  logic [ADDR_W-1:0] xorHpa;
  logic [ADDR_W-1:0] nextHpa;

  always_comb begin
    cut          = {1'b0, granCode} + CUT_W'(8);
    lowMask      = ~({ADDR_W{1'b1}} << cut);
    lowBits      = devOffset & lowMask;
    upperInPlace = devOffset & ~lowMask;
    upperJust    = devOffset >> cut;
    posWide      = ADDR_W'(targetPos);
    // power-of-two path: field stays in place, slot fills the gap
    pow2Sum      = (upperInPlace << strobe.waysShift) | (posWide << cut) | lowBits;
    // three-based path: x*3 as shift-add
    tripled      = (upperJust << 1) + upperJust;
    triSum       = (((tripled << strobe.waysShift) + posWide) << cut) + lowBits;
    modHpa       = strobe.triple ? triSum : pow2Sum;
  end

  ilv_xlate_xor #(
    .ADDR_W  (ADDR_W),
    .NUM_MAPS(NUM_MAPS),
    .MAPS    (MAPS)
  ) xor_i (
    .addrIn    (modHpa),
    .stageCount(strobe.xorStages),
    .addrOut   (xorHpa)
  );

  always_comb begin
    if (strobe.fault)       nextHpa = '1;
    else if (strobe.useXor) nextHpa = xorHpa;
    else                    nextHpa = modHpa;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            hostOffset <= '0;
    else if (strobe.load) hostOffset <= nextHpa;
  end

  // R2: granule-offset bits of a good request land unchanged
  p_low_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.fault && !strobe.useXor) |=>
      ((hostOffset & $past(lowMask)) == ($past(devOffset) & $past(lowMask))));

endmodule

// File: rtl/ilv_addr_xlate.sv
module ilv_addr_xlate
  import ilv_xlate_pkg::*;
#(
  parameter int ADDR_W   = 52,
  parameter int POS_W    = 4,
  parameter int GRAN_MAX = 6,
  parameter int NUM_MAPS = 4,
  parameter logic [NUM_MAPS-1:0][ADDR_W-1:0] MAPS =
    {52'h0000000000800, 52'h0000001010400, 52'h0000004041200, 52'h0000002020900}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] devOffset,
  input  logic [POS_W-1:0]  targetPos,
  input  logic [3:0]        waysCode,
  input  logic [3:0]        granCode,
  input  logic [3:0]        hostWaysCode,
  input  logic              xorMode,
  output logic              outValid,
  output logic              outError,
  output logic [ADDR_W-1:0] hostOffset
);

  xlateStrobeT strobe;

  ilv_xlate_ctrl #(
    .POS_W   (POS_W),
    .GRAN_MAX(GRAN_MAX)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .targetPos   (targetPos),
    .waysCode    (waysCode),
    .granCode    (granCode),
    .hostWaysCode(hostWaysCode),
    .xorMode     (xorMode),
    .strobe      (strobe),
    .outValid    (outValid),
    .outError    (outError)
  );

  ilv_xlate_dp #(
    .ADDR_W  (ADDR_W),
    .POS_W   (POS_W),
    .NUM_MAPS(NUM_MAPS),
    .MAPS    (MAPS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .devOffset (devOffset),
    .targetPos (targetPos),
    .granCode  (granCode),
    .hostOffset(hostOffset)
  );

  // R1: a flagged result carries the all-ones address
  p_fault_ones_r1: assert property (@(posedge clk) disable iff (!rstN)
    outError |-> (hostOffset == {ADDR_W{1'b1}}));
  // R6: address holds without a request
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(hostOffset));
  // R7: out-of-range slot is flagged
  p_bad_pos_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (int'(targetPos) >= int'(waysCount(waysCode)))) |=> outError);

endmodule

// File: tb/ilv_addr_xlate_tb.sv
module ilv_addr_xlate_tb_top;

  localparam longint unsigned MASK52 = (64'd1 << 52) - 64'd1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [51:0] devOffset = '0;
  logic [3:0]  targetPos = '0;
  logic [3:0]  waysCode = '0;
  logic [3:0]  granCode = '0;
  logic [3:0]  hostWaysCode = '0;
  logic        xorMode = 1'b0;
  logic        outValid;
  logic        outError;
  logic [51:0] hostOffset;

  int checks = 0;
  int errors = 0;

  typedef struct {
    longint unsigned hpa;
    bit              err;
    string           tag;
  } expT;
  expT q[$];

  always #2 clk = ~clk;

  ilv_addr_xlate dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .devOffset(devOffset),
    .targetPos(targetPos), .waysCode(waysCode), .granCode(granCode),
    .hostWaysCode(hostWaysCode), .xorMode(xorMode),
    .outValid(outValid), .outError(outError), .hostOffset(hostOffset)
  );

  function automatic int decodeWays(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;  4: return 16;
      8: return 3;  9: return 6;  10: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic int stagesFor(int c);
    case (c)
      1, 9: return 1;
      2, 10: return 2;
      3: return 3;
      4: return 4;
      default: return 0;
    endcase
  endfunction

  // expected host offset from the requirement formulas (R2..R5)
  function automatic longint unsigned model(longint unsigned dpa, int pos, int w,
                                            int g, int hb, bit x);
    longint unsigned maps [4] = '{64'h2020900, 64'h4041200, 64'h1010400, 64'h800};
    longint unsigned gsize = 64'd1 << (g + 8);
    longint unsigned hpa;
    hpa = (((dpa / gsize) * longint'(decodeWays(w)) + longint'(pos)) * gsize
           + (dpa % gsize)) & MASK52;
    if (x) begin
      for (int s = 0; s < stagesFor(hb); s++) begin
        bit par = 1'b0;
        int piv = -1;
        for (int b = 0; b < 52; b++) begin
          if (maps[s][b]) begin
            if (piv < 0) piv = b;
            par ^= hpa[b];
          end
        end
        hpa[piv] = par;
      end
    end
    return hpa;
  endfunction

  task automatic send(longint unsigned dpa, int pos, int w, int g, int hb, bit x,
                      longint unsigned expHpa, bit expErr, string tag);
    expT e;
    @(negedge clk);
    devOffset    = dpa[51:0];
    targetPos    = pos[3:0];
    waysCode     = w[3:0];
    granCode     = g[3:0];
    hostWaysCode = hb[3:0];
    xorMode      = x;
    inValid      = 1'b1;
    e.hpa = expErr ? MASK52 : expHpa;
    e.err = expErr;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic sendModel(longint unsigned dpa, int pos, int w, int g, int hb, bit x,
                           string tag);
    send(dpa, pos, w, g, hb, x, model(dpa, pos, w, g, hb, x), 1'b0, tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && outValid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected outValid: actual=1 expected=0");
        end else begin
          expT e;
          e = q.pop_front();
          if ({12'd0, hostOffset} != e.hpa || outError != e.err) begin
            errors++;
            $display("FAIL %s: actual hpa=%0d err=%0b expected hpa=%0d err=%0b",
                     e.tag, hostOffset, outError, e.hpa, e.err);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outError !== 1'b0 || hostOffset !== '0) begin
      errors++;
      $display("FAIL R9 reset: actual v=%0b e=%0b a=%0d expected 0 0 0",
               outValid, outError, hostOffset);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3: 4 ways, gran 0, offset 256
    for (int p = 0; p < 4; p++) send(256, p, 2, 0, 2, 0, 1024 + 256 * p, 0, "R3 4way");
    // R5: same sample in XOR mode is unchanged
    for (int p = 0; p < 4; p++) send(256, p, 2, 0, 2, 1, 1024 + 256 * p, 0, "R5 4way xor");
    // R4: 12 ways, offset 512, modulo
    for (int p = 0; p < 12; p++) send(512, p, 10, 0, 10, 0, 6144 + 256 * p, 0, "R4 12way");
    idle(2);
    // R5: XOR literal samples
    send(512, 0, 10, 0, 10, 1, 6912, 0, "R5 12way xor p0");
    send(512, 1, 10, 0, 10, 1, 6656, 0, "R5 12way xor p1");
    send(16, 1, 2, 0, 2, 1, 272, 0, "R5 4way xor");
    send(16400, 1, 3, 0, 2, 1, 131088, 0, "R5 8way xor");
    send(443953523, 0, 2, 0, 2, 1, 1775813747, 0, "R5 large");
    sendModel(64'h12345678, 9, 4, 1, 4, 1, "R5 16way 4 stages");
    // R4: 3-way and 6-way
    send(256, 2, 8, 0, 0, 0, 1280, 0, "R4 3way");
    sendModel(64'h0ABCDE, 5, 9, 2, 9, 0, "R4 6way");
    // R2: low bits kept at a wide granule
    send(64'h7FF, 1, 1, 3, 1, 0, 64'hFFF, 0, "R2 gran3");
    sendModel(64'h3ABC, 15, 4, 6, 4, 0, "R2 gran6");
    idle(1);
    // R1: illegal way codes
    send(256, 0, 5, 0, 0, 0, 0, 1, "R1 code5");
    send(256, 0, 7, 0, 0, 0, 0, 1, "R1 code7");
    send(256, 0, 15, 0, 0, 0, 0, 1, "R1 code15");
    // R7: slot range
    send(256, 4, 2, 0, 2, 0, 0, 1, "R7 pos4 of 4");
    send(256, 3, 8, 0, 0, 0, 0, 1, "R7 pos3 of 3");
    sendModel(256, 11, 10, 0, 10, 0, "R7 pos11 of 12 ok");
    // R8: granularity limit
    send(256, 0, 1, 7, 1, 0, 0, 1, "R8 gran7");
    sendModel(256, 1, 1, 6, 1, 0, "R8 gran6 ok");
    // R10: host code only matters in XOR mode
    send(256, 1, 2, 0, 6, 0, 1280, 0, "R10 modulo ignores host code");
    send(256, 1, 2, 0, 6, 1, 0, 1, "R10 xor bad host code");
    idle(3);

    // mixed patterns
    begin
      longint unsigned s = 64'h9E3779B97F4A7C15;
      int wl [8] = '{0, 1, 2, 3, 4, 8, 9, 10};
      for (int i = 0; i < 40; i++) begin
        int w, g, hb, p;
        s ^= s << 13; s ^= s >> 7; s ^= s << 17;
        w  = wl[s[2:0]];
        hb = wl[s[5:3]];
        g  = int'(s[8:6]) % 7;
        p  = int'(s[15:12]) % decodeWays(w);
        sendModel(s[39:0] >> 4, p, w, g, hb, s[9], s[9] ? "R5 mixed" : "R3 R4 mixed");
      end
    end
    idle(4);

    // R6: every queued result has arrived, nothing extra
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 leftover: actual=%0d expected=0", q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule